// File: doc/BRIEF.md
# Asynchronous External Memory Cycle Controller

This block turns one single-beat host request into one complete bus cycle on an asynchronous parallel memory that latches its address from an address-valid strobe. The host raises a request with a direction flag, a 26-bit address and, for writes, 16-bit data. The controller then runs the cycle through four phases: address setup with the strobe low, address hold with the strobe high, a data phase and, for writes only, a one-clock tail. It then reports completion with a one-clock done pulse. Read data is returned on the same clock as the pulse.

Each phase length comes from a set of timing inputs. One set serves reads. A second set serves writes when separate write timing is switched on; otherwise writes use the read set. Each set also holds a turnaround value. This value keeps chip enable high for a minimum number of clocks before the controller will start the next cycle. The timing set, the address and the write data are all captured when the request is accepted, so the host may change these inputs while the cycle runs.

Top module: `amc_ctrl`

## Requirements
- R1: After reset and while no request is served, mem_ce_no, mem_adv_no, mem_oe_no and mem_we_no are 1, and mem_dq_oe_o and done_o are 0.
- R2: A cycle begins with mem_ce_no falling and mem_adv_no low. mem_adv_no stays low for exactly A+1 clocks, where A is the selected address-setup value.
- R3: After setup, mem_adv_no is high and both mem_oe_no and mem_we_no are high for exactly H+1 clocks, where H is the selected address-hold value.
- R4: In a write, mem_we_no is low for max(D,1) clocks, where D is the selected data-setup value. One clock follows with mem_we_no high and mem_ce_no still low.
- R5: In a read, mem_oe_no is low for D+3 clocks and mem_we_no stays high. rdata_o takes the value present on mem_dq_i during the last clock with mem_oe_no low.
- R6: mem_dq_oe_o is 1 only in a write, from the first data-phase clock through the tail clock (max(D,1)+1 clocks). During that time mem_dq_o carries the accepted write data. At all other times mem_dq_oe_o is 0.
- R7: The write set (wr_*) times a cycle only when wr_sep_en_i=1 and the cycle is a write. Every other cycle uses the read set (rd_*), and this includes its turnaround value.
- R8: With req_i held at 1, mem_ce_no stays high for exactly T+1 clocks between two cycles, where T is the turnaround value of the earlier cycle.
- R9: done_o is 1 for exactly one clock per cycle. That clock is the first one after mem_ce_no rises.
- R10: The address, write data, direction and timing set are captured at acceptance. Changes to these inputs during a cycle have no effect on mem_addr_o, mem_dq_o or the phase lengths.
- R11: A request is accepted only when the controller is idle. A request that rises and falls inside the turnaround gap starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_addr_setup_i | input | 4 | Read set: address-setup value |
| rd_addr_hold_i | input | 4 | Read set: address-hold value |
| rd_data_setup_i | input | 8 | Read set: data-setup value |
| rd_turn_i | input | 4 | Read set: turnaround value |
| wr_sep_en_i | input | 1 | Selects the separate write timing set for writes |
| wr_addr_setup_i | input | 4 | Write set: address-setup value |
| wr_addr_hold_i | input | 4 | Write set: address-hold value |
| wr_data_setup_i | input | 8 | Write set: data-setup value |
| wr_turn_i | input | 4 | Write set: turnaround value |
| req_i | input | 1 | Host request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 26 | Host address |
| wdata_i | input | 16 | Host write data |
| rdata_o | output | 16 | Read data, valid with done_o |
| done_o | output | 1 | One-clock completion pulse |
| mem_addr_o | output | 26 | Memory address |
| mem_adv_no | output | 1 | Address-valid strobe, active low |
| mem_ce_no | output | 1 | Chip enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_dq_o | output | 16 | Data bus, outgoing value |
| mem_dq_i | input | 16 | Data bus, incoming value |
| mem_dq_oe_o | output | 1 | Data bus drive enable |

## Verification
The done pulse of one cycle and the acceptance of the next request meet in the same clocks. The bench holds req_i high from the clock in which done_o appears, so the turnaround countdown and the idle acceptance run back to back. For every timing combination it counts the high clocks on mem_ce_no against T+1. In the same cycles it changes the address, data, direction and timing inputs just after chip enable falls. The bench then checks that phase lengths, address and data still follow the values captured at acceptance. Read data comes from a bus value that changes on every output-enable clock, so capture on any clock other than the last one shows up as a wrong value.

// File: rtl/amc_pkg.sv
package amc_pkg;
  localparam int AS_W = 4;
  localparam int AH_W = 4;
  localparam int DS_W = 8;
  localparam int TG_W = 4;
  localparam int CNT_W = DS_W + 1;

  typedef struct packed {
    logic [AS_W-1:0] addr_setup;
    logic [AH_W-1:0] addr_hold;
    logic [DS_W-1:0] data_setup;
    logic [TG_W-1:0] turn;
  } timing_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_HOLD, ST_DATA, ST_TAIL, ST_GAP
  } state_e;
endpackage

// File: rtl/amc_timing_sel.sv
module amc_timing_sel
  import amc_pkg::*;
(
  input  timing_t rd_tim_i,
  input  timing_t wr_tim_i,
  input  logic    sep_en_i,
  input  logic    we_i,
  output timing_t tim_o
);
  assign tim_o = (sep_en_i && we_i) ? wr_tim_i : rd_tim_i;
endmodule

// File: rtl/amc_seq.sv
module amc_seq
  import amc_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  input  logic    we_i,
  input  timing_t tim_i,
  output state_e  st_o,
  output logic    wr_o,
  output logic    done_o,
  output logic    accept_o,
  output logic    cap_o
);
  state_e           st_q;
  timing_t          tim_q;
  logic             wr_q;
  logic             done_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign accept_o = (st_q == ST_IDLE) && req_i;
  assign cap_o    = (st_q == ST_DATA) && !wr_q && cnt_zero;
  assign st_o     = st_q;
  assign wr_o     = wr_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      tim_q  <= '0;
      wr_q   <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          st_q  <= ST_SETUP;
          tim_q <= tim_i;
          wr_q  <= we_i;
          cnt_q <= CNT_W'(tim_i.addr_setup);
        end
        ST_SETUP: if (cnt_zero) begin
          st_q  <= ST_HOLD;
          cnt_q <= CNT_W'(tim_q.addr_hold);
        end else cnt_q <= cnt_q - CNT_W'(1);
        ST_HOLD: if (cnt_zero) begin
          st_q <= ST_DATA;
          // write strobe lasts max(D,1); read strobe lasts D+3
          if (wr_q)
            cnt_q <= (tim_q.data_setup == '0) ? '0 : CNT_W'(tim_q.data_setup) - CNT_W'(1);
          else
            cnt_q <= CNT_W'(tim_q.data_setup) + CNT_W'(2);
        end else cnt_q <= cnt_q - CNT_W'(1);
        ST_DATA: if (cnt_zero) begin
          if (wr_q) st_q <= ST_TAIL;
          else begin
            done_q <= 1'b1;
            st_q   <= (tim_q.turn == '0) ? ST_IDLE : ST_GAP;
            cnt_q  <= CNT_W'(tim_q.turn) - CNT_W'(1);
          end
        end else cnt_q <= cnt_q - CNT_W'(1);
        ST_TAIL: begin
          done_q <= 1'b1;
          st_q   <= (tim_q.turn == '0) ? ST_IDLE : ST_GAP;
          cnt_q  <= CNT_W'(tim_q.turn) - CNT_W'(1);
        end
        ST_GAP: if (cnt_zero) st_q <= ST_IDLE;
                else cnt_q <= cnt_q - CNT_W'(1);
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/amc_datapath.sv
module amc_datapath #(
  parameter int AW = 26,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          cap_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] dq_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
      rdata_o <= '0;
    end else begin
      if (accept_i) begin
        addr_o  <= addr_i;
        wdata_o <= wdata_i;
      end
      if (cap_i) rdata_o <= dq_i;
    end
  end
endmodule

// File: rtl/amc_ctrl.sv
module amc_ctrl
  import amc_pkg::*;
#(
  parameter int AW = 26,
  parameter int DW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AS_W-1:0] rd_addr_setup_i,
  input  logic [AH_W-1:0] rd_addr_hold_i,
  input  logic [DS_W-1:0] rd_data_setup_i,
  input  logic [TG_W-1:0] rd_turn_i,
  input  logic            wr_sep_en_i,
  input  logic [AS_W-1:0] wr_addr_setup_i,
  input  logic [AH_W-1:0] wr_addr_hold_i,
  input  logic [DS_W-1:0] wr_data_setup_i,
  input  logic [TG_W-1:0] wr_turn_i,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            done_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic            mem_adv_no,
  output logic            mem_ce_no,
  output logic            mem_oe_no,
  output logic            mem_we_no,
  output logic [DW-1:0]   mem_dq_o,
  input  logic [DW-1:0]   mem_dq_i,
  output logic            mem_dq_oe_o
);
  timing_t rd_tim, wr_tim, sel_tim;
  state_e  st;
  logic    wr, accept, cap;

  assign rd_tim = '{addr_setup: rd_addr_setup_i, addr_hold: rd_addr_hold_i,
                    data_setup: rd_data_setup_i, turn: rd_turn_i};
  assign wr_tim = '{addr_setup: wr_addr_setup_i, addr_hold: wr_addr_hold_i,
                    data_setup: wr_data_setup_i, turn: wr_turn_i};

  amc_timing_sel u_sel (
    .rd_tim_i(rd_tim), .wr_tim_i(wr_tim), .sep_en_i(wr_sep_en_i),
    .we_i(we_i), .tim_o(sel_tim)
  );

  amc_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .tim_i(sel_tim), .st_o(st), .wr_o(wr), .done_o(done_o),
    .accept_o(accept), .cap_o(cap)
  );

  amc_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(accept), .cap_i(cap),
    .addr_i(addr_i), .wdata_i(wdata_i), .dq_i(mem_dq_i),
    .addr_o(mem_addr_o), .wdata_o(mem_dq_o), .rdata_o(rdata_o)
  );

  assign mem_ce_no   = (st == ST_IDLE) || (st == ST_GAP);
  assign mem_adv_no  = (st != ST_SETUP);
  assign mem_we_no   = !((st == ST_DATA) && wr);
  assign mem_oe_no   = !((st == ST_DATA) && !wr);
  assign mem_dq_oe_o = wr && ((st == ST_DATA) || (st == ST_TAIL));
endmodule

// File: rtl/amc_ctrl_chk.sv
module amc_ctrl_chk #(
  parameter int AW = 26
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_ce_no,
  input logic          mem_adv_no,
  input logic          mem_oe_no,
  input logic          mem_we_no,
  input logic          mem_dq_oe_o,
  input logic          done_o,
  input logic [AW-1:0] mem_addr_o
);
  assert_cycle_starts_latch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_ce_no) |-> !mem_adv_no);
  assert_strobe_inside_ce_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_adv_no |-> !mem_ce_no);
  assert_no_oe_we_overlap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_no && !mem_we_no));
  assert_we_drives_bus_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> mem_dq_oe_o);
  assert_drive_inside_ce_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> !mem_ce_no);
  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_after_ce_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> mem_ce_no);
  assert_addr_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && $past(!mem_ce_no)) |-> $stable(mem_addr_o));
endmodule

bind amc_ctrl amc_ctrl_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_ce_no(mem_ce_no), .mem_adv_no(mem_adv_no),
  .mem_oe_no(mem_oe_no), .mem_we_no(mem_we_no), .mem_dq_oe_o(mem_dq_oe_o),
  .done_o(done_o), .mem_addr_o(mem_addr_o)
);

// File: tb/tb_amc_ctrl.sv
module tb_amc_ctrl;
  logic clk_i = 0, rst_ni = 0;
  logic [3:0] rd_addr_setup_i = 0, rd_addr_hold_i = 0, rd_turn_i = 0;
  logic [7:0] rd_data_setup_i = 0;
  logic wr_sep_en_i = 0;
  logic [3:0] wr_addr_setup_i = 0, wr_addr_hold_i = 0, wr_turn_i = 0;
  logic [7:0] wr_data_setup_i = 0;
  logic req_i = 0, we_i = 0;
  logic [25:0] addr_i = 0;
  logic [15:0] wdata_i = 0, rdata_o, mem_dq_o, mem_dq_i = 0;
  logic done_o, mem_adv_no, mem_ce_no, mem_oe_no, mem_we_no, mem_dq_oe_o;
  logic [25:0] mem_addr_o;

  int n_chk = 0, n_fail = 0;
  bit ended = 0;
  int c_ras, c_rah, c_rds, c_rtg, c_was, c_wah, c_wds, c_wtg;
  bit c_ext;
  int prev_tg = 0;

  always #10 clk_i = ~clk_i;

  amc_ctrl dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive_cfg();
    rd_addr_setup_i = 4'(c_ras); rd_addr_hold_i = 4'(c_rah);
    rd_data_setup_i = 8'(c_rds); rd_turn_i = 4'(c_rtg);
    wr_addr_setup_i = 4'(c_was); wr_addr_hold_i = 4'(c_wah);
    wr_data_setup_i = 8'(c_wds); wr_turn_i = 4'(c_wtg);
    wr_sep_en_i = c_ext;
  endtask

  // Call at a negedge; returns at the negedge where done_o is seen.
  task automatic xfer(input bit w, input logic [25:0] a, input logic [15:0] d,
                      input bit chained, input logic [15:0] base);
    int nset = 0, nhold = 0, nwe = 0, noe = 0, ntail = 0, ndq = 0, hi;
    int eas, eah, eds, etg, dsw;
    bit started = 0, fin = 0, abad = 0, dbad = 0, lastlow = 0, usew;
    logic [15:0] rd;
    usew = w && c_ext;
    eas = usew ? c_was : c_ras; eah = usew ? c_wah : c_rah;
    eds = usew ? c_wds : c_rds; etg = usew ? c_wtg : c_rtg;
    dsw = (eds == 0) ? 1 : eds;
    drive_cfg();
    we_i = w; addr_i = a; wdata_i = d; req_i = 1;
    hi = chained ? 1 : 0;
    while (!fin) begin
      @(negedge clk_i);
      if (done_o) begin
        chk(started && lastlow, "R9 done first clock after ce rise", int'(lastlow), 1);
        rd = rdata_o; fin = 1;
      end else if (mem_ce_no) begin
        if (!started) hi++;
        lastlow = 0;
      end else begin
        if (!started) begin
          started = 1; req_i = 0;
          if (chained) chk(hi == prev_tg + 1, "R8 ce high gap", hi, prev_tg + 1);
          // R10: disturb every captured input mid-cycle
          addr_i = ~a; wdata_i = ~d; we_i = ~w; wr_sep_en_i = ~c_ext;
          rd_addr_setup_i = 4'hF; rd_addr_hold_i = 4'hF; rd_data_setup_i = 8'hFF;
          wr_addr_setup_i = 4'hF; wr_addr_hold_i = 4'hF; wr_data_setup_i = 8'hFF;
        end
        lastlow = 1;
        if (mem_addr_o !== a) abad = 1;
        if (!mem_adv_no) nset++;
        else if (!mem_we_no) nwe++;
        else if (!mem_oe_no) begin noe++; mem_dq_i = base + 16'(noe); end
        else if (nwe == 0 && noe == 0) nhold++;
        else ntail++;
        if (mem_dq_oe_o) begin ndq++; if (mem_dq_o !== d) dbad = 1; end
      end
    end
    drive_cfg();
    chk(nset == eas + 1, "R2 setup clocks", nset, eas + 1);
    chk(nhold == eah + 1, "R3 hold clocks", nhold, eah + 1);
    chk(!abad, "R10 address held", int'(abad), 0);
    if (w) begin
      chk(nwe == dsw, "R4 we low clocks", nwe, dsw);
      chk(ntail == 1 && noe == 0, "R4 tail clock", ntail, 1);
      chk(ndq == dsw + 1, "R6 write drive clocks", ndq, dsw + 1);
      chk(!dbad, "R10 write data held", int'(dbad), 0);
      chk(nset + nhold + nwe + ntail == eas + eah + dsw + 3, "R7 write cycle length",
          nset + nhold + nwe + ntail, eas + eah + dsw + 3);
    end else begin
      chk(noe == eds + 3 && nwe == 0, "R5 oe low clocks", noe, eds + 3);
      chk(ntail == 0, "R5 no tail on read", ntail, 0);
      chk(rd == base + 16'(eds + 3), "R5 read data", int'(rd), int'(base + 16'(eds + 3)));
      chk(ndq == 0, "R6 no drive on read", ndq, 0);
      chk(nset + nhold + noe == eas + eah + eds + 5, "R7 read cycle length",
          nset + nhold + noe, eas + eah + eds + 5);
    end
    prev_tg = etg;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!ended) begin
      ended = 1; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int k = 0;
    bit first = 1;
    bit ok;
    c_ras = 0; c_rah = 0; c_rds = 0; c_rtg = 0;
    c_was = 0; c_wah = 0; c_wds = 0; c_wtg = 0; c_ext = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    ok = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      if (!(mem_ce_no && mem_adv_no && mem_oe_no && mem_we_no && !mem_dq_oe_o && !done_o)) ok = 0;
    end
    chk(ok, "R1 idle outputs after reset", int'(ok), 1);

    for (int as = 0; as <= 2; as += 2)
      for (int ah = 0; ah <= 1; ah++)
        for (int ds = 0; ds <= 3; ds++) begin
          if (ds == 2) continue;
          for (int tg = 0; tg <= 2; tg += 2)
            for (int ex = 0; ex <= 1; ex++)
              for (int dir = 0; dir <= 1; dir++) begin
                c_ras = as; c_rah = ah; c_rds = ds; c_rtg = tg;
                c_was = (as + 1) % 3; c_wah = ah + 1; c_wds = ds + 1; c_wtg = tg + 1;
                c_ext = bit'(ex);
                xfer(bit'(dir), 26'(k * 40503 + 7), 16'(k * 997 + 3), !first, 16'(k * 37));
                first = 0; k++;
              end
        end

    // R11: a request pulsed inside the gap starts nothing
    c_ras = 1; c_rah = 0; c_rds = 1; c_rtg = 3; c_ext = 0;
    xfer(1'b0, 26'h155_5555, 16'h0, 1'b1, 16'h4000);
    req_i = 1;
    @(negedge clk_i);
    req_i = 0;
    ok = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      if (!mem_ce_no || done_o) ok = 0;
    end
    chk(ok, "R11 gap request ignored", int'(ok), 1);
    xfer(1'b1, 26'h2AA_AAAA, 16'hA5C3, 1'b0, 16'h0);
    ok = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      if (!(mem_ce_no && !mem_dq_oe_o && !done_o)) ok = 0;
    end
    chk(ok, "R1 idle again with no request", int'(ok), 1);

    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule